// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control sequencer for a multicycle processor datapath in which a single memory and a single ALU are reused across the cycles of each instruction. It supports load word, store word, register-register arithmetic, branch-on-equal and jump. It also has two trap paths: one for an opcode it does not recognise, and one for an arithmetic overflow on a register-register result. Each instruction takes three to five cycles, counting the fetch cycle. A trap adds one cycle that records the cause, saves the faulting address and redirects the program counter to a fixed handler address.

The controller is a Moore machine with one exception: a single gate on the register write enable. Its outputs are decoded from a 4-bit state register holding states 0 to 11. The opcode field of the instruction register and the ALU overflow flag are its only data inputs. It drives every multiplexer select and every write enable of the datapath. The datapath itself lies outside the block.

Select encodings:
- ALU second operand select (`alu_b_sel`):
  - 00: register B
  - 01: the constant four
  - 10: the sign-extended immediate
  - 11: the immediate shifted left by two
- Program counter source (`pc_src`):
  - 00: the live ALU result
  - 01: the registered ALU output
  - 10: the jump target
  - 11: the fixed trap handler address
- ALU operation class (`alu_op`):
  - 00: add
  - 01: subtract
  - 10: taken from the function field

Top module: `mcc_control`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` low) puts the controller in the fetch state at once, and it stays there while reset is held.
- R2: Fetch state outputs and exit:
  - The fetch state drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_data_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00.
  - The next state is always decode.
- R3: Decode state outputs and dispatch:
  - The decode state drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00.
  - It then dispatches on the opcode: 35 (load) or 43 (store) go to address calculation, 0 goes to register execute, 4 to branch and 2 to jump.
- R4: Undefined opcode trap:
  - Any other opcode in decode leads to the undefined-opcode trap state.
  - That state drives `exc_code`=0, `cause_wr`=1, `epc_wr`=1, `pc_wr`=1, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=01 and `pc_src`=11.
  - Fetch follows it.
- R5: Load path, five cycles in total:
  1. Address calculation drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00.
  2. Memory read drives `mem_rd`=1 and `addr_data_sel`=1.
  3. Write-back drives `rf_wr`=1, `rf_dst_rd`=0 and `wb_from_mem`=1.
  4. Fetch follows.
- R6: Store path, four cycles in total: after address calculation, one cycle drives `mem_wr`=1 and `addr_data_sel`=1, then fetch follows.
- R7: Register-register path, four cycles in total:
  1. Execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10.
  2. Completion drives `rf_wr`=1, `rf_dst_rd`=1 and `wb_from_mem`=0.
  3. Fetch follows.
- R8: Overflow trap:
  - If `alu_ovf` is high during the register completion cycle, `rf_wr` stays 0 in that cycle.
  - The next state is the overflow trap. It has the same outputs as the undefined-opcode trap except `exc_code`=1.
  - Fetch follows it.
- R9: Branch path, three cycles in total: one cycle drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_wr_cond`=1 and `pc_src`=01, then fetch follows.
- R10: Jump path, three cycles in total: one cycle drives `pc_wr`=1 and `pc_src`=10, then fetch follows.
- R11: Every control output not named for a state is 0 in that state. `alu_ovf` has no effect in any state other than register completion.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU overflow flag |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when ALU zero |
| addr_data_sel | output | 1 | Memory address from ALU output (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from memory data register |
| pc_src | output | 2 | Program counter source select |
| alu_op | output | 2 | ALU operation class |
| alu_a_sel | output | 1 | ALU first operand: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU second operand select |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination from rd field (1) or rt field (0) |
| exc_code | output | 1 | Trap cause: 0 undefined opcode, 1 overflow |
| cause_wr | output | 1 | Cause register write |
| epc_wr | output | 1 | Faulting-address register write |

## Verification
Every state has its own output pattern, so a wrong state or a wrong transition shows at the ports on the very next clock edge as a mismatched select or write enable. The symptoms are a cycle that is too long or too short, a stray write, or a missing return to fetch. The bench compares every cycle of every instruction path against a per-state pattern. These paths include the two traps, overflow raised in a cycle where it must not matter, and reset taken in the middle of an instruction. Any divergence is therefore caught in the cycle it first appears.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LOAD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STORE  = 4'd5,
    S_EXEC   = 4'd6,
    S_RWB    = 4'd7,
    S_BEQ    = 4'd8,
    S_JMP    = 4'd9,
    S_UNDEF  = 4'd10,
    S_OVF    = 4'd11
  } state_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_data_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       exc_code;
    logic       cause_wr;
    logic       epc_wr;
  } ctl_t;

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  state_e nxt,
  output state_e state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= nxt;
  end

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state <= S_OVF);

endmodule

// File: rtl/mcc_dispatch.sv
module mcc_dispatch
  import mcc_pkg::*;
#(
  parameter int                OPC_W    = 6,
  parameter logic [OPC_W-1:0]  OP_RTYPE = 6'd0,
  parameter logic [OPC_W-1:0]  OP_LOAD  = 6'd35,
  parameter logic [OPC_W-1:0]  OP_STORE = 6'd43,
  parameter logic [OPC_W-1:0]  OP_BEQ   = 6'd4,
  parameter logic [OPC_W-1:0]  OP_JMP   = 6'd2
) (
  input  state_e           state,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output state_e           nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nxt = S_ADDR;
        else if (opcode == OP_RTYPE)                 nxt = S_EXEC;
        else if (opcode == OP_BEQ)                   nxt = S_BEQ;
        else if (opcode == OP_JMP)                   nxt = S_JMP;
        else                                         nxt = S_UNDEF;
      end
      S_ADDR:   nxt = (opcode == OP_LOAD) ? S_LOAD : S_STORE;
      S_LOAD:   nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      S_RWB:    nxt = alu_ovf ? S_OVF : S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
  import mcc_pkg::*;
(
  input  state_e state,
  input  logic   alu_ovf,
  output ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    unique case (state)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      S_LOAD: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_data_sel = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      S_STORE: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_data_sel = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_op    = 2'b10;
      end
      S_RWB: begin
        ctl.rf_wr     = ~alu_ovf;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BEQ: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_op     = 2'b01;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = 2'b01;
      end
      S_JMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = 2'b10;
      end
      S_UNDEF, S_OVF: begin
        ctl.exc_code  = (state == S_OVF);
        ctl.cause_wr  = 1'b1;
        ctl.epc_wr    = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = 2'b01;
        ctl.alu_op    = 2'b01;
        ctl.pc_src    = 2'b11;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcc_control.sv
module mcc_control
  import mcc_pkg::*;
#(
  parameter int                OPC_W    = 6,
  parameter logic [OPC_W-1:0]  OP_RTYPE = 6'd0,
  parameter logic [OPC_W-1:0]  OP_LOAD  = 6'd35,
  parameter logic [OPC_W-1:0]  OP_STORE = 6'd43,
  parameter logic [OPC_W-1:0]  OP_BEQ   = 6'd4,
  parameter logic [OPC_W-1:0]  OP_JMP   = 6'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_data_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             wb_from_mem,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr,
  output logic             rf_dst_rd,
  output logic             exc_code,
  output logic             cause_wr,
  output logic             epc_wr
);

  state_e state;
  state_e nxt;
  ctl_t   ctl;

  mcc_state_reg u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt),
    .state (state)
  );

  mcc_dispatch #(
    .OPC_W    (OPC_W),
    .OP_RTYPE (OP_RTYPE),
    .OP_LOAD  (OP_LOAD),
    .OP_STORE (OP_STORE),
    .OP_BEQ   (OP_BEQ),
    .OP_JMP   (OP_JMP)
  ) u_dispatch (
    .state   (state),
    .opcode  (opcode),
    .alu_ovf (alu_ovf),
    .nxt     (nxt)
  );

  mcc_out_decode u_decode (
    .state   (state),
    .alu_ovf (alu_ovf),
    .ctl     (ctl)
  );

  assign pc_wr         = ctl.pc_wr;
  assign pc_wr_cond    = ctl.pc_wr_cond;
  assign addr_data_sel = ctl.addr_data_sel;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign ir_wr         = ctl.ir_wr;
  assign wb_from_mem   = ctl.wb_from_mem;
  assign pc_src        = ctl.pc_src;
  assign alu_op        = ctl.alu_op;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign rf_wr         = ctl.rf_wr;
  assign rf_dst_rd     = ctl.rf_dst_rd;
  assign exc_code      = ctl.exc_code;
  assign cause_wr      = ctl.cause_wr;
  assign epc_wr        = ctl.epc_wr;

  logic op_known;
  assign op_known = (opcode == OP_RTYPE) || (opcode == OP_LOAD) || (opcode == OP_STORE)
                 || (opcode == OP_BEQ) || (opcode == OP_JMP);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (!ir_wr && alu_b_sel == 2'b11));

  assert_undef_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_b_sel == 2'b11 && !op_known) |=> (cause_wr && !exc_code));

  assert_trap_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ir_wr);

  assert_regwrite_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> ir_wr);

  assert_no_overflow_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_dst_rd && alu_ovf) |-> !rf_wr);

  assert_overflow_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_dst_rd && alu_ovf) |=> (cause_wr && exc_code));

  assert_branch_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr);

  assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

// File: tb/mcc_control_test.sv
module mcc_control_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic       alu_ovf = 1'b0;
  logic pc_wr, pc_wr_cond, addr_data_sel, mem_rd, mem_wr, ir_wr, wb_from_mem;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, rf_wr, rf_dst_rd, exc_code, cause_wr, epc_wr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mcc_control uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_data_sel(addr_data_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_from_mem(wb_from_mem),
    .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .exc_code(exc_code),
    .cause_wr(cause_wr), .epc_wr(epc_wr)
  );

  logic [18:0] obs;
  assign obs = {pc_wr, pc_wr_cond, addr_data_sel, mem_rd, mem_wr, ir_wr, wb_from_mem,
                pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd, exc_code,
                cause_wr, epc_wr};

  // Expected outputs per state, written from the requirement list.
  function automatic logic [18:0] exp_vec(input int s, input logic ov);
    logic pw = 0, pwc = 0, ads = 0, mr = 0, mw = 0, iw = 0, wfm = 0;
    logic [1:0] ps = 0, op = 0, bs = 0;
    logic as = 0, rw = 0, rd = 0, ec = 0, cw = 0, ew = 0;
    case (s)
      0:  begin mr = 1; iw = 1; pw = 1; bs = 2'b01; end
      1:  bs = 2'b11;
      2:  begin as = 1; bs = 2'b10; end
      3:  begin mr = 1; ads = 1; end
      4:  begin rw = 1; wfm = 1; end
      5:  begin mw = 1; ads = 1; end
      6:  begin as = 1; op = 2'b10; end
      7:  begin rw = !ov; rd = 1; end
      8:  begin as = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      9:  begin pw = 1; ps = 2'b10; end
      default: begin ec = (s == 11); cw = 1; ew = 1; pw = 1; bs = 2'b01;
                     op = 2'b01; ps = 2'b11; end
    endcase
    return {pw, pwc, ads, mr, mw, iw, wfm, ps, op, as, bs, rw, rd, ec, cw, ew};
  endfunction

  task automatic check_now(input logic [18:0] e, input string tag);
    checks++;
    if (obs !== e) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, obs, e);
    end
  endtask

  // Driver: called at a negedge with the controller in fetch; pushes the
  // expected pattern of every following cycle, ending back in fetch.
  task automatic run_instr(input logic [5:0] op, input logic ov, input int n,
                           input int s0, input int s1, input int s2, input int s3,
                           input int s4, input string tag);
    int seq[5];
    seq = '{s0, s1, s2, s3, s4};
    opcode  = op;
    alu_ovf = ov;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_vec(seq[i], ov));
      tag_q.push_back(tag);
    end
    repeat (n) @(negedge clk);
  endtask

  // Monitor: samples 3 ns after each rising edge.
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #2;
    check_now(exp_vec(0, 0), "R1 reset state");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    run_instr(6'd35, 0, 5, 1, 2, 3, 4, 0, "R5 load path");
    run_instr(6'd43, 0, 4, 1, 2, 5, 0, 0, "R6 store path");
    run_instr(6'd0,  0, 4, 1, 6, 7, 0, 0, "R7 register path");
    run_instr(6'd0,  1, 5, 1, 6, 7, 11, 0, "R8 overflow trap");
    run_instr(6'd4,  0, 3, 1, 8, 0, 0, 0, "R9 branch path");
    run_instr(6'd2,  0, 3, 1, 9, 0, 0, 0, "R10 jump path");
    run_instr(6'd1,  0, 3, 1, 10, 0, 0, 0, "R4 undefined opcode 1");
    run_instr(6'd63, 0, 3, 1, 10, 0, 0, 0, "R4 undefined opcode 63");
    run_instr(6'd34, 0, 3, 1, 10, 0, 0, 0, "R3 R4 near-load opcode 34");
    run_instr(6'd35, 1, 5, 1, 2, 3, 4, 0, "R11 overflow ignored on load");
    run_instr(6'd43, 1, 4, 1, 2, 5, 0, 0, "R11 R12 overflow ignored on store");
    run_instr(6'd4,  1, 3, 1, 8, 0, 0, 0, "R11 overflow ignored on branch");
    run_instr(6'd5,  1, 3, 1, 10, 0, 0, 0, "R4 undefined opcode with overflow");
    run_instr(6'd0,  0, 4, 1, 6, 7, 0, 0, "R2 fetch after trap");

    // Reset taken in the middle of a load.
    opcode = 6'd35; alu_ovf = 0;
    repeat (3) @(negedge clk);
    check_now(exp_vec(3, 0), "R5 memory read before reset");
    #1 rst_n = 1'b0;
    #1 check_now(exp_vec(0, 0), "R1 asynchronous reset mid-instruction");
    @(negedge clk);
    check_now(exp_vec(0, 0), "R1 fetch held in reset");
    rst_n = 1'b1;
    run_instr(6'd2, 0, 3, 1, 9, 0, 0, 0, "R10 jump after reset");
    @(negedge clk);

    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual=%0d expected=0 pending items", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule